// File: doc/BRIEF.md
# Iterative ARX Permutation Core

This core applies a run of steps of an add-rotate-XOR permutation to a state of NB branches. Each branch holds two 32-bit words, x and y, so the state is 2*NB words wide. Every step has three parts. The first injects constants into the first two branches. The second passes every branch through a four-round ARX box. The third is a Feistel-style diffusion layer. The core performs one whole step per clock cycle. Its datapath is combinational and spans all branches.

A client presents a state and a step count, then pulses `start` while the core is idle. `busy` stays high for exactly as many cycles as steps were requested. `done` then pulses for one cycle, and `state_out` carries the permuted state at that point. The eight 32-bit round constants are fixed inside the core, and that fixes the number of branches at eight or fewer.

Top module: `iter_arx_perm`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: The core takes a `start` that is high while `busy` is low as the start of a run. If `num_steps` = N > 0, `busy` is high for the next N cycles and `done` is low during those cycles. In the cycle after them `done` is 1 for one cycle and `busy` is 0.
- R3: If `num_steps` = 0, `done` is 1 in the cycle after the start is taken, and `state_out` equals the `state_in` that was sampled.
- R4: A `start` pulse while `busy` is high has no effect. The run keeps its step count and its state, and `state_in` and `num_steps` are ignored.
- R5: Step i runs with i = 0 first, up to N-1. At the start of step i, the y word of branch 0 is XORed with K[i mod 8] and the y word of branch 1 is XORed with i. K = B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D (hex), indexed 0 to 7.
- R6: After injection, branch b passes through the box with c = K[b]. The box runs four rounds, each with rotate-right amounts (a, d). The pairs in order are (31,24), (17,17), (0,31) and (24,16). Each round computes x += ror(y,a), then y ^= ror(x,d), then x ^= c.
- R7: The diffusion layer works on halves of h = NB/2 branches. It forms tx and ty as the XOR of the x words and of the y words over the left half. Each is then mapped by L(v) = ror(v ^ (v<<16), 16). New left branch j takes x = oldx[(j+1) mod h] ^ oldx[h+(j+1) mod h] ^ L(ty) and y = oldy[(j+1) mod h] ^ oldy[h+(j+1) mod h] ^ L(tx). New right branch h+j is old left branch j.
- R8: Word w of the state occupies bits [32w+31:32w] of `state_in` and `state_out`. Branch b has x in word 2b and y in word 2b+1.
- R9: Outside a run, `state_out` holds its value until the next start is taken. A start in the cycle where `done` is high is taken.
- R10: The core gives results that match R5 to R7 for NB = 4, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; taken only while idle |
| state_in | input | 64*NB | State loaded when a start is taken |
| num_steps | input | SW | Number of steps for the run |
| busy | output | 1 | High during each step cycle |
| done | output | 1 | One-cycle pulse when the final state is valid |
| state_out | output | 64*NB | Current state register |

## Verification
Two events can fall in the same cycle. The first is the end of a run, with its `done` pulse, and the start of the next run. The bench provokes this by starting each run in the cycle where the previous run's `done` is high. It then checks the new run's busy window and its per-step state against the model. A zero-step start also lands in that cycle, and its `done` must pulse again in the very next cycle. The second collision is a start against a step in progress. The bench drives `start` with changed inputs in mid-run and checks that the step sequence and the run length stay unchanged.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;

  localparam int WORD_W  = 32;
  localparam int K_COUNT = 8;

  typedef logic [WORD_W-1:0] word_t;

  // Round constant table, indexed modulo 8
  function automatic word_t rcon(input int idx);
    case (idx & 7)
      0:       return 32'hB7E15162;
      1:       return 32'hBF715880;
      2:       return 32'h38B4DA56;
      3:       return 32'h324E7738;
      4:       return 32'hBB1185EB;
      5:       return 32'h4F7C7B57;
      6:       return 32'hCFBFA1C8;
      default: return 32'hC2B3293D;
    endcase
  endfunction

  function automatic word_t rotr(input word_t v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction

  // Diffusion mixing function
  function automatic word_t ell(input word_t v);
    return rotr(v ^ (v << 16), 16);
  endfunction

  // Four-round ARX box; branch packed as {y, x}
  function automatic logic [2*WORD_W-1:0] arx_box(input logic [2*WORD_W-1:0] br,
                                                  input word_t c);
    word_t x;
    word_t y;
    x = br[WORD_W-1:0];
    y = br[2*WORD_W-1:WORD_W];
    x = x + rotr(y, 31); y = y ^ rotr(x, 24); x = x ^ c;
    x = x + rotr(y, 17); y = y ^ rotr(x, 17); x = x ^ c;
    x = x + y;           y = y ^ rotr(x, 31); x = x ^ c;
    x = x + rotr(y, 24); y = y ^ rotr(x, 16); x = x ^ c;
    return {y, x};
  endfunction

endpackage

// File: rtl/arx_box_layer.sv
module arx_box_layer
  import arx_perm_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic [2*NB*WORD_W-1:0] layer_in,
  output logic [2*NB*WORD_W-1:0] layer_out
);
  localparam int BR_W = 2 * WORD_W;

  // One box per branch, each with its own constant
  for (genvar b = 0; b < NB; b++) begin : g_box
    assign layer_out[b*BR_W +: BR_W] = arx_box(layer_in[b*BR_W +: BR_W], rcon(b));
  end

endmodule

// File: rtl/arx_diffusion.sv
module arx_diffusion
  import arx_perm_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic [2*NB*WORD_W-1:0] diff_in,
  output logic [2*NB*WORD_W-1:0] diff_out
);
  localparam int HALF = NB / 2;

  word_t xw [NB];
  word_t yw [NB];
  word_t tx_mix;
  word_t ty_mix;

  for (genvar b = 0; b < NB; b++) begin : g_unpack
    assign xw[b] = diff_in[(2*b)*WORD_W   +: WORD_W];
    assign yw[b] = diff_in[(2*b+1)*WORD_W +: WORD_W];
  end

  always_comb begin
    word_t tx;
    word_t ty;
    tx = '0;
    ty = '0;
    for (int b = 0; b < HALF; b++) begin
      tx = tx ^ xw[b];
      ty = ty ^ yw[b];
    end
    tx_mix = ell(tx);
    ty_mix = ell(ty);
  end

  for (genvar j = 0; j < HALF; j++) begin : g_feistel
    localparam int SRC = (j + 1) % HALF;
    // New left branch j from old branches SRC and HALF+SRC
    assign diff_out[(2*j)*WORD_W   +: WORD_W] = xw[SRC] ^ xw[HALF+SRC] ^ ty_mix;
    assign diff_out[(2*j+1)*WORD_W +: WORD_W] = yw[SRC] ^ yw[HALF+SRC] ^ tx_mix;
    // New right half is the old left half
    assign diff_out[(2*(HALF+j))*WORD_W   +: WORD_W] = xw[j];
    assign diff_out[(2*(HALF+j)+1)*WORD_W +: WORD_W] = yw[j];
  end

endmodule

// File: rtl/iter_arx_perm.sv
module iter_arx_perm
  import arx_perm_pkg::*;
#(
  parameter int NB = 8,  // branches, even, 2..8
  parameter int SW = 8   // step count width, below 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2*NB*WORD_W-1:0] state_in,
  input  logic [SW-1:0]          num_steps,
  output logic                   busy,
  output logic                   done,
  output logic [2*NB*WORD_W-1:0] state_out
);
  localparam int ST_W = 2 * NB * WORD_W;

  logic [ST_W-1:0] st_q;
  logic [SW-1:0]   idx_q;
  logic [SW-1:0]   last_q;
  logic            busy_q;
  logic            done_q;

  // Named events for the checks below
  logic accept;
  logic final_step;
  assign accept     = start && !busy_q;
  assign final_step = busy_q && (idx_q == last_q);

  // Constant injection
  logic [ST_W-1:0] inj;
  always_comb begin
    inj = st_q;
    inj[2*WORD_W-1:WORD_W]   = st_q[2*WORD_W-1:WORD_W] ^ rcon(int'(idx_q));
    inj[4*WORD_W-1:3*WORD_W] = st_q[4*WORD_W-1:3*WORD_W] ^ 32'(idx_q);
  end

  logic [ST_W-1:0] boxed;
  logic [ST_W-1:0] step_out;

  arx_box_layer #(.NB(NB)) u_box (
    .layer_in  (inj),
    .layer_out (boxed)
  );

  arx_diffusion #(.NB(NB)) u_diff (
    .diff_in  (boxed),
    .diff_out (step_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      idx_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q   <= state_in;
        idx_q  <= '0;
        last_q <= num_steps - SW'(1);
        busy_q <= (num_steps != '0);
        done_q <= (num_steps == '0);
      end else if (busy_q) begin
        st_q  <= step_out;
        idx_q <= idx_q + SW'(1);
        if (final_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign state_out = st_q;

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_run_begins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && num_steps != '0) |=> (busy && idx_q == '0));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_zero_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && num_steps == '0) |=> (done && state_out == $past(state_in)));

  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !final_step) |=> (busy && idx_q == $past(idx_q) + SW'(1)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(state_out));

endmodule

// File: tb/iter_arx_perm_bench.sv
`timescale 1ns/1ps
module iter_arx_perm_bench;
  localparam int SW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     start_v = '0;
  logic [511:0]   sin = '0;
  logic [SW-1:0]  nsteps = '0;
  logic [2:0]     busy_v;
  logic [2:0]     done_v;
  logic [255:0]   so4;
  logic [383:0]   so6;
  logic [511:0]   so8;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iter_arx_perm #(.NB(4), .SW(SW)) u_iter_arx_perm (
    .clk(clk), .rst_n(rst_n), .start(start_v[0]), .state_in(sin[255:0]),
    .num_steps(nsteps), .busy(busy_v[0]), .done(done_v[0]), .state_out(so4));

  iter_arx_perm #(.NB(6), .SW(SW)) u_iter_arx_perm_nb6 (
    .clk(clk), .rst_n(rst_n), .start(start_v[1]), .state_in(sin[383:0]),
    .num_steps(nsteps), .busy(busy_v[1]), .done(done_v[1]), .state_out(so6));

  iter_arx_perm #(.NB(8), .SW(SW)) u_iter_arx_perm_nb8 (
    .clk(clk), .rst_n(rst_n), .start(start_v[2]), .state_in(sin),
    .num_steps(nsteps), .busy(busy_v[2]), .done(done_v[2]), .state_out(so8));

  // ---------------- reference model ----------------
  logic [31:0] kt [8] = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56, 32'h324E7738,
                          32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
  int add_rot [4] = '{31, 17, 0, 24};
  int xor_rot [4] = '{24, 17, 31, 16};
  logic [31:0] mw [16];

  function automatic logic [31:0] rr(input logic [31:0] v, input int n);
    logic [63:0] d;
    d = {v, v} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] mixl(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ {v[15:0], 16'h0};
    return {t[15:0], t[31:16]};
  endfunction

  task automatic model_step(input int nb, input int i);
    logic [31:0] nw [16];
    logic [31:0] x, y, tx, ty;
    int h;
    h = nb / 2;
    mw[1] = mw[1] ^ kt[i % 8];
    mw[3] = mw[3] ^ 32'(i);
    for (int b = 0; b < nb; b++) begin
      x = mw[2*b]; y = mw[2*b+1];
      for (int r = 0; r < 4; r++) begin
        x = x + rr(y, add_rot[r]);
        y = y ^ rr(x, xor_rot[r]);
        x = x ^ kt[b];
      end
      mw[2*b] = x; mw[2*b+1] = y;
    end
    tx = 0; ty = 0;
    for (int b = 0; b < h; b++) begin
      tx ^= mw[2*b]; ty ^= mw[2*b+1];
    end
    tx = mixl(tx); ty = mixl(ty);
    for (int b = 0; b < h; b++) begin
      int s;
      s = (b + 1) % h;
      nw[2*b]       = mw[2*s] ^ mw[2*(h+s)] ^ ty;
      nw[2*b+1]     = mw[2*s+1] ^ mw[2*(h+s)+1] ^ tx;
      nw[2*(h+b)]   = mw[2*b];
      nw[2*(h+b)+1] = mw[2*b+1];
    end
    for (int w = 0; w < 2*nb; w++) mw[w] = nw[w];
  endtask

  function automatic logic [511:0] model_vec(input int nb);
    logic [511:0] v;
    v = '0;
    for (int w = 0; w < 2*nb; w++) v[32*w +: 32] = mw[w];
    return v;
  endfunction

  function automatic logic [511:0] dut_out(input int sel);
    if (sel == 0) return {256'h0, so4};
    if (sel == 1) return {128'h0, so6};
    return so8;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_input(input int nb, input int seed);
    int s;
    s = seed;
    sin = '0;
    for (int w = 0; w < 16; w++) mw[w] = 0;
    for (int w = 0; w < 2*nb; w++) begin
      s = s * 1103515245 + 12345;
      mw[w] = 32'(s) ^ {16'(s >>> 7), 16'(w)};
      sin[32*w +: 32] = mw[w];
    end
  endtask

  // Begins at a negedge; ends at the negedge where done is expected high
  task automatic run_case(input int sel, input int nsv, input int seed, input bit poke);
    int nb;
    logic [511:0] in_copy;
    nb = 4 + 2*sel;
    load_input(nb, seed);
    in_copy = sin;
    nsteps = SW'(nsv);
    start_v[sel] = 1'b1;
    @(negedge clk);
    start_v[sel] = 1'b0;
    if (nsv == 0) begin
      chk(done_v[sel] && !busy_v[sel], "R3 done", {510'h0, busy_v[sel], done_v[sel]}, 512'h1);
      chk(dut_out(sel) == in_copy, "R3 state", dut_out(sel), in_copy);
      return;
    end
    for (int c = 0; c < nsv; c++) begin
      chk(busy_v[sel] && !done_v[sel], "R2 busy window",
          {510'h0, busy_v[sel], done_v[sel]}, 512'h2);
      chk(dut_out(sel) == model_vec(nb), "R5 R6 R7 R8 step state",
          dut_out(sel), model_vec(nb));
      if (poke && c == 2) begin
        start_v[sel] = 1'b1;  // R4: must be ignored
        nsteps = SW'(1);
        sin = ~sin;
      end
      if (poke && c == 3) start_v[sel] = 1'b0;
      model_step(nb, c);
      @(negedge clk);
    end
    chk(done_v[sel] && !busy_v[sel], poke ? "R4 run length" : "R2 done pulse",
        {510'h0, busy_v[sel], done_v[sel]}, 512'h1);
    chk(dut_out(sel) == model_vec(nb), poke ? "R4 final state" : "R10 final state",
        dut_out(sel), model_vec(nb));
  endtask

  task automatic hold_check(input int sel);
    logic [511:0] held;
    held = dut_out(sel);
    nsteps = SW'(5);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!done_v[sel] && !busy_v[sel], "R9 idle flags",
          {510'h0, busy_v[sel], done_v[sel]}, 512'h0);
      chk(dut_out(sel) == held, "R9 state held", dut_out(sel), held);
    end
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_v == 3'b0 && done_v == 3'b0, "R1 flags in reset", {506'h0, busy_v, done_v}, 512'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_v == 3'b0 && done_v == 3'b0, "R1 flags", {506'h0, busy_v, done_v}, 512'h0);
    chk(so8 == '0 && so6 == '0 && so4 == '0, "R1 state", so8, 512'h0);

    // NB = 4: runs chained so each start lands in the previous done cycle
    run_case(0, 7, 11, 1'b0);
    run_case(0, 11, 23, 1'b0);
    run_case(0, 0, 37, 1'b0);
    run_case(0, 0, 41, 1'b0);
    hold_check(0);

    // NB = 6: a mid-run start is poked in
    run_case(1, 7, 53, 1'b0);
    run_case(1, 11, 67, 1'b1);
    run_case(1, 0, 71, 1'b0);
    hold_check(1);

    // NB = 8: include a run past eight steps so the constant index wraps
    run_case(2, 7, 89, 1'b0);
    run_case(2, 11, 97, 1'b0);
    run_case(2, 20, 101, 1'b1);
    hold_check(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule